// File: doc/BRIEF.md
# Reset Cause Capture Controller

This block takes the reset requests of a small system (power-on and supply monitor, external pin, watchdog overflow, missing-clock timeout, comparator, flash error, and software) and merges them into one system reset output. Several of these sources can be switched on or off. The block also records which source started the most recent reset, so that boot code can learn why the system restarted.

Software reaches the block through one 8-bit register on a simple bus. The write side and the read side of this register have different meanings. A write sets the enables of the optional sources, or forces a software reset. A read returns the latched cause flags and never returns the enables. For this reason, software must not update the register with read-modify-write.

After the last cycle of any request, the reset output stays asserted for a fixed number of cycles. The analog monitors, the watchdog counter and the clock detector are outside the block. They reach it as request inputs.

Top module: `rcc_top`

## Requirements
- R1: A read (`bus_rd`=1) at address 0xEF returns the cause flags in these positions: bit 0 pin, bit 1 power-on/supply monitor, bit 2 missing clock, bit 3 watchdog, bit 4 software, bit 5 comparator, bit 6 flash error. Bit 7 reads 0. Any other address, or no read strobe, returns 0x00.
- R2: While `por_n` is low, `sys_rst` is 1. When `por_n` is released, `sys_rst` stays asserted for 16 more cycles and the flags read 0x02. Power-on also clears the comparator and missing-clock enables and sets the supply-monitor enable.
- R3: A pin, watchdog or flash-error request always causes a reset. It sets only its own flag (0x01, 0x08 or 0x40).
- R4: Writing a 1 to bit 4 at address 0xEF forces a reset, and afterwards the flags read 0x10. A write to any other address has no effect.
- R5: A write at address 0xEF loads the comparator enable from bit 5, the missing-clock enable from bit 2 and the supply-monitor enable from bit 1. Writing 0 clears an enable. Reads never return the enables.
- R6: While a source's enable is clear, a comparator-low level, a missing-clock timeout or a supply-monitor trip causes no reset and leaves the flags unchanged.
- R7: When enabled, a low `cmp_out` sets flag 0x20, `mclk_timeout` sets 0x04 and `vmon_trip` sets 0x02. Each of them also causes a reset.
- R8: If several sources request in the same cycle, only one flag is set. The order from highest to lowest is: supply monitor, pin, missing clock, watchdog, software, comparator, flash error.
- R9: `sys_rst` rises at the clock edge that samples a request. It stays high until 16 edges have passed with no request.
- R10: Flags are latched only in the first cycle of a reset. A request that arrives while `sys_rst` is already high extends the hold time but does not change the flags.
- R11: Bit 7 ignores writes. Writing it causes no reset and leaves bit 7 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vmon_trip | input | 1 | Supply monitor trip request |
| pin_rst | input | 1 | External reset pin request |
| mclk_timeout | input | 1 | Missing-clock timeout request |
| wdt_ovf | input | 1 | Watchdog overflow request |
| cmp_out | input | 1 | Comparator output; a low level requests a reset |
| flash_err | input | 1 | Flash error request |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sys_rst | output | 1 | System reset, active high |

## Verification
A request sampled at clock edge E raises `sys_rst` right after E, and the cause flags are latched at that same edge. The bench drives stimulus on falling edges and holds each request until the next falling edge. From that next falling edge, it counts consecutive falling-edge samples of `sys_rst`, and expects exactly 16. Reads are combinational, so each read is sampled 1 ns after the address and strobe are applied, well before the next rising edge. Checks that expect "no effect" look at `sys_rst` on three falling edges after the stimulus, then read the flags back.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   // Request index = priority rank (0 is highest).
   localparam int NSRC       = 7;
   localparam int SRC_SUPPLY = 0;
   localparam int SRC_PIN    = 1;
   localparam int SRC_MCLK   = 2;
   localparam int SRC_WDOG   = 3;
   localparam int SRC_SOFT   = 4;
   localparam int SRC_CMP    = 5;
   localparam int SRC_FLASH  = 6;

   // Register bit positions (software decodes these).
   localparam int BIT_PIN    = 0;
   localparam int BIT_SUPPLY = 1;
   localparam int BIT_MCLK   = 2;
   localparam int BIT_WDOG   = 3;
   localparam int BIT_SOFT   = 4;
   localparam int BIT_CMP    = 5;
   localparam int BIT_FLASH  = 6;

   function automatic int bit_of(input int src);
      case (src)
         SRC_SUPPLY: bit_of = BIT_SUPPLY;
         SRC_PIN:    bit_of = BIT_PIN;
         SRC_MCLK:   bit_of = BIT_MCLK;
         SRC_WDOG:   bit_of = BIT_WDOG;
         SRC_SOFT:   bit_of = BIT_SOFT;
         SRC_CMP:    bit_of = BIT_CMP;
         default:    bit_of = BIT_FLASH;
      endcase
   endfunction
endpackage

// File: rtl/rcc_regif.sv
module rcc_regif #(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'hEF
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-2:0] flags,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cmp_en,
   output logic              mclk_en,
   output logic              supply_en,
   output logic              soft_req
);
   import rcc_pkg::*;

   logic hit;
   assign hit = (bus_addr == REG_ADDR);

   // Write-only enable register, never visible on reads.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cmp_en    <= 1'b0;
         mclk_en   <= 1'b0;
         supply_en <= 1'b1;
      end else if (bus_wr && hit) begin
         cmp_en    <= bus_wdata[BIT_CMP];
         mclk_en   <= bus_wdata[BIT_MCLK];
         supply_en <= bus_wdata[BIT_SUPPLY];
      end
   end

   assign soft_req  = bus_wr & hit & bus_wdata[BIT_SOFT];
   assign bus_rdata = (bus_rd && hit) ? {1'b0, flags} : '0;
endmodule

// File: rtl/rcc_prio.sv
module rcc_prio #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_rank
         assign grant[i]     = req[i] & ~blocked[i];
         assign blocked[i+1] = blocked[i] | req[i];
      end
   endgenerate

   assign any = blocked[N];
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic req_any,
   output logic active,
   output logic start
);
   localparam int CNT_W = $clog2(HOLD + 1);
   localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              cnt <= HOLD_V;
      else if (req_any)        cnt <= HOLD_V;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
   assign start  = req_any & ~active;
endmodule

// File: rtl/rcc_top.sv
module rcc_top #(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR    = 8'hEF,
   parameter int                HOLD_CYCLES = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              vmon_trip,
   input  logic              pin_rst,
   input  logic              mclk_timeout,
   input  logic              wdt_ovf,
   input  logic              cmp_out,
   input  logic              flash_err,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sys_rst
);
   import rcc_pkg::*;

   localparam int FLAG_W = DATA_W - 1;
   localparam logic [FLAG_W-1:0] FLAG_POR = FLAG_W'(1) << BIT_SUPPLY;

   generate
      if (DATA_W != NSRC + 1) begin : g_bad_width
         $error("DATA_W must equal source count plus one");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic cmp_en, mclk_en, supply_en, soft_req;
   logic [NSRC-1:0]   req, grant;
   logic              req_any, start;
   logic [FLAG_W-1:0] flag_next, flag_q;

   rcc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_regif (
      .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .flags(flag_q),
      .bus_rdata(bus_rdata), .cmp_en(cmp_en), .mclk_en(mclk_en),
      .supply_en(supply_en), .soft_req(soft_req)
   );

   // Gated requests in priority order.
   assign req[SRC_SUPPLY] = vmon_trip & supply_en;
   assign req[SRC_PIN]    = pin_rst;
   assign req[SRC_MCLK]   = mclk_timeout & mclk_en;
   assign req[SRC_WDOG]   = wdt_ovf;
   assign req[SRC_SOFT]   = soft_req;
   assign req[SRC_CMP]    = ~cmp_out & cmp_en;
   assign req[SRC_FLASH]  = flash_err;

   rcc_prio #(.N(NSRC)) u_prio (.req(req), .grant(grant), .any(req_any));

   rcc_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
      .clk(clk), .por_n(por_n), .req_any(req_any), .active(sys_rst), .start(start)
   );

   generate
      for (genvar k = 0; k < NSRC; k++) begin : g_map
         localparam int P = bit_of(k);
         assign flag_next[P] = grant[k];
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      flag_q <= FLAG_POR;
      else if (start)  flag_q <= flag_next;
   end
endmodule

// File: rtl/rcc_chk.sv
module rcc_chk (
   input logic       clk,
   input logic       por_n,
   input logic       pin_rst,
   input logic       wdt_ovf,
   input logic       bus_rd,
   input logic [7:0] bus_rdata,
   input logic       sys_rst,
   input logic [6:0] flags
);
   a_r1_bit7_low: assert property (@(posedge clk) disable iff (!por_n)
      bus_rdata[7] == 1'b0);

   a_r8_single_flag: assert property (@(posedge clk) disable iff (!por_n)
      bus_rd |-> $onehot0(bus_rdata));

   a_r3_pin_asserts: assert property (@(posedge clk) disable iff (!por_n)
      pin_rst |=> sys_rst);

   a_r3_wdog_asserts: assert property (@(posedge clk) disable iff (!por_n)
      wdt_ovf |=> sys_rst);

   a_r9_no_early_release: assert property (@(posedge clk) disable iff (!por_n)
      $fell(sys_rst) |-> (!$past(pin_rst) && !$past(wdt_ovf)));

   a_r10_latch_at_start: assert property (@(posedge clk) disable iff (!por_n)
      !$stable(flags) |-> $rose(sys_rst));
endmodule

bind rcc_top rcc_chk u_chk (
   .clk(clk), .por_n(por_n), .pin_rst(pin_rst), .wdt_ovf(wdt_ovf),
   .bus_rd(bus_rd), .bus_rdata(bus_rdata), .sys_rst(sys_rst), .flags(flag_q)
);

// File: tb/tb_rcc_top.sv
`timescale 1ns/1ps
module tb_rcc_top;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       vmon_trip = 1'b0, pin_rst = 1'b0, mclk_timeout = 1'b0;
   logic       wdt_ovf = 1'b0, cmp_out = 1'b1, flash_err = 1'b0;
   logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       sys_rst;
   int checks = 0, errors = 0;

   localparam logic [7:0] RA = 8'hEF;

   always #2 clk = ~clk;

   rcc_top dut (
      .clk(clk), .por_n(por_n), .vmon_trip(vmon_trip), .pin_rst(pin_rst),
      .mclk_timeout(mclk_timeout), .wdt_ovf(wdt_ovf), .cmp_out(cmp_out),
      .flash_err(flash_err), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_rst(sys_rst)
   );

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // mask uses register bit positions; bit 5 drives cmp_out low
   task automatic apply(input logic [7:0] m, input int n);
      @(negedge clk);
      pin_rst = m[0]; vmon_trip = m[1]; mclk_timeout = m[2];
      wdt_ovf = m[3]; cmp_out = ~m[5]; flash_err = m[6];
      repeat (n) @(negedge clk);
      pin_rst = 0; vmon_trip = 0; mclk_timeout = 0;
      wdt_ovf = 0; cmp_out = 1; flash_err = 0;
   endtask

   task automatic count_rst(output int n);
      n = 0;
      while (sys_rst && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic expect_event(input string rq, input logic [7:0] flag);
      int n;
      logic [7:0] v;
      count_rst(n);
      chk({rq, " hold"}, n, 16);
      rd(RA, v);
      chk({rq, " flags"}, v, flag);
   endtask

   task automatic expect_quiet(input string rq, input logic [7:0] flag);
      logic [7:0] v;
      for (int i = 0; i < 3; i++) begin
         chk({rq, " no reset"}, sys_rst, 0);
         @(negedge clk);
      end
      rd(RA, v);
      chk({rq, " flags kept"}, v, flag);
   endtask

   task automatic t_power_on();
      int n;
      logic [7:0] v;
      por_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 reset while por_n low", sys_rst, 1);
      por_n = 1'b1;
      count_rst(n);
      chk("R2 hold after power-on", n, 16);
      rd(RA, v);
      chk("R2 R1 power-on flags", v, 8'h02);
   endtask

   task automatic t_default_enables();
      apply(8'h20, 1); expect_quiet("R6 R2 comparator off by default", 8'h02);
      apply(8'h04, 1); expect_quiet("R6 R2 missing clock off by default", 8'h02);
      apply(8'h02, 1); expect_event("R7 R2 supply monitor on by default", 8'h02);
   endtask

   task automatic t_fixed_sources();
      apply(8'h01, 1); expect_event("R3 pin", 8'h01);
      apply(8'h08, 1); expect_event("R3 watchdog", 8'h08);
      apply(8'h40, 1); expect_event("R3 flash", 8'h40);
   endtask

   task automatic t_software();
      logic [7:0] v;
      wr(RA, 8'h10); expect_event("R4 software", 8'h10);
      wr(8'hEE, 8'h10); expect_quiet("R4 other address write", 8'h10);
      rd(8'hEE, v); chk("R1 other address read", v, 8'h00);
      @(negedge clk); #1 chk("R1 no strobe read", bus_rdata, 8'h00);
   endtask

   task automatic t_enables();
      wr(RA, 8'h24); expect_quiet("R5 enable write hidden", 8'h10);
      apply(8'h04, 1); expect_event("R7 missing clock", 8'h04);
      apply(8'h20, 1); expect_event("R7 comparator", 8'h20);
      apply(8'h02, 1); expect_quiet("R6 R5 supply monitor cleared", 8'h20);
   endtask

   task automatic t_bit7();
      logic [7:0] v;
      wr(RA, 8'hA4); expect_quiet("R11 bit7 write", 8'h20);
      rd(RA, v); chk("R11 bit7 reads 0", v[7], 0);
   endtask

   task automatic t_priority();
      apply(8'h09, 1); expect_event("R8 pin over watchdog", 8'h01);
      apply(8'h4C, 1); expect_event("R8 mclk over watchdog/flash", 8'h04);
      apply(8'h28, 1); expect_event("R8 watchdog over comparator", 8'h08);
      apply(8'h60, 1); expect_event("R8 comparator over flash", 8'h20);
      @(negedge clk);
      bus_addr = RA; bus_wdata = 8'h34; bus_wr = 1'b1; cmp_out = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0; cmp_out = 1'b1;
      expect_event("R8 software over comparator", 8'h10);
      wr(RA, 8'h06); expect_quiet("R5 enable write", 8'h10);
      apply(8'h03, 1); expect_event("R8 supply over pin", 8'h02);
   endtask

   task automatic t_stretch();
      int n;
      logic [7:0] v;
      apply(8'h01, 5); expect_event("R9 long pin request", 8'h01);
      apply(8'h40, 1);
      repeat (5) @(negedge clk);
      apply(8'h08, 1);
      count_rst(n);
      chk("R10 R9 hold restarts", n, 16);
      rd(RA, v);
      chk("R10 flags not relatched", v, 8'h40);
   endtask

   task automatic t_power_on_again();
      wr(RA, 8'h24);
      t_power_on();
      apply(8'h20, 1); expect_quiet("R2 comparator enable cleared", 8'h02);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_power_on();
      t_default_enables();
      t_fixed_sources();
      t_software();
      t_enables();
      t_bit7();
      t_priority();
      t_stretch();
      t_power_on_again();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule